// File: doc/BRIEF.md
# Fuse Bank Parallel Read Sequencer

This block fetches one 32-bit word from a small one-time-programmable fuse bank over the bank's parallel read interface. A one-cycle `start` pulse carries a bank choice (a three-word bank or a four-word bank) and a word index. For an accepted request the sequencer works through a fixed bring-up order on the fuse control lines. It selects parallel mode, releases the macro from power-on reset, enables pointer auto-increment and pulses the read-pointer reset. It then gives the read-data strobe a high-low-high pattern with a guaranteed minimum low time.

After the strobe the sequencer reads every word of the bank in turn, each one after a long settle wait. The fuse macro advances its own read pointer after each read. Only the word at the requested index is kept on `rd_word`. When the request ends, `done` pulses for one cycle, `status` gives the outcome and the control lines return to their idle values.

A request whose index is outside the bank is refused at once, and so is a programming request. Neither one drives the fuse interface. Every wait is derived from a clock-frequency parameter and rounded up, so the minimum times hold at any clock rate.

Top module: `otp_par_rd_seq`

## Requirements
- R1: After reset `busy`, `done`, `otp_ptr_inc` and `otp_rd_en` are 0, `status` is 0, `rd_word` is 0, and `otp_ctrl` is 16'h8000: the mode bit is set and all other bits are clear.
- R2: An accepted request changes the control lines in this order, one step per cycle or later: the mode bit (bit 15 of `otp_ctrl`) is cleared, the reset-release bit (bit 13) is set, `otp_ptr_inc` is set, and the pointer-reset bit (bit 14) is high for exactly one cycle.
- R3: After the pointer-reset pulse, the strobe bit (bit 3 of `otp_ctrl`) goes high for one cycle and then low. It stays low for at least ceil(STROBE_LOW_NS*CLK_MHZ/1000) cycles and then goes high again.
- R4: Each `otp_rd_en` pulse comes at least ceil(SETTLE_NS*CLK_MHZ/1000) cycles after the final strobe rise or the previous read pulse. At each pulse the mode bit is 0, and the reset-release bit, `otp_ptr_inc` and the strobe bit are all 1.
- R5: With `bank_sel`=0 a request makes exactly NORTH_WORDS (3) read pulses. With `bank_sel`=1 it makes exactly SOUTH_WORDS (4). `otp_bank` holds the bank being read.
- R6: A valid request ends with `status`=0 and `rd_word` equal to the word returned by the read pulse at position `word_idx`, counting from 0.
- R7: A `word_idx` at or above the size of the selected bank ends the request with `status`=1. It makes no change on the fuse lines and leaves `rd_word` unchanged.
- R8: A request with `prog_req`=1 ends with `status`=2 (unsupported). This outcome takes priority over the index check. It makes no change on the fuse lines and leaves `rd_word` unchanged.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is ignored. `done` is high for exactly one cycle.
- R10: When a request ends, `otp_ctrl` returns to 16'h8000 and `otp_ptr_inc` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| bank_sel | input | 1 | 0 = three-word bank, 1 = four-word bank |
| word_idx | input | IDX_W | Requested word index |
| prog_req | input | 1 | Programming request (always refused) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 index out of range, 2 unsupported |
| rd_word | output | DATA_W | Word selected by the last valid request |
| otp_ctrl | output | 16 | Fuse control word: bit 15 mode, 14 pointer reset, 13 reset release, 3 strobe |
| otp_ptr_inc | output | 1 | Pointer auto-increment enable |
| otp_rd_en | output | 1 | Read-port access pulse |
| otp_bank | output | 1 | Bank being addressed |
| otp_rd_data | input | DATA_W | Read-port data from the fuse macro |

## Verification
A wrong state in the sequencer shows up first on the fuse control lines. A skipped or reordered bring-up step breaks the recorded edge order within about ten cycles of `start`. A short strobe count shows as a low time under the bound at the moment the strobe rises again. An off-by-one in the word counter shows within one settle period, as a wrong number of read pulses or a wrong `rd_word` when `done` pulses. The sweep covers every bank, every index value up to twice the bank size, and both values of `prog_req`, so each refusal path is compared with an undisturbed interface and output.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
   localparam int CTRL_W      = 16;
   localparam int BIT_MODE    = 15;
   localparam int BIT_PRST    = 14;
   localparam int BIT_PORB    = 13;
   localparam int BIT_STRB    = 3;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_BADIX = 2'd1,
      ST_UNSUP = 2'd2
   } seq_status_e;

   typedef enum logic [3:0] {
      S_IDLE, S_MODE, S_POR, S_PINC, S_RSET, S_RCLR,
      S_SHI, S_SLO, S_SHI2, S_WAIT, S_READ, S_FIN, S_DONE
   } seq_state_e;

   function automatic int ns_to_cyc(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction
endpackage

// File: rtl/otp_dly_cnt.sv
module otp_dly_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_word_latch.sv
module otp_word_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout <= '0;
      else if (take)  dout <= din;
   end
endmodule

// File: rtl/otp_par_rd_seq.sv
module otp_par_rd_seq
   import otp_seq_pkg::*;
#(
   parameter int CLK_MHZ       = 200,
   parameter int STROBE_LOW_NS = 100,
   parameter int SETTLE_NS     = 100000,
   parameter int DATA_W        = 32,
   parameter int NORTH_WORDS   = 3,
   parameter int SOUTH_WORDS   = 4,
   localparam int MAX_WORDS    = (NORTH_WORDS > SOUTH_WORDS) ? NORTH_WORDS : SOUTH_WORDS,
   localparam int IDX_W        = $clog2(MAX_WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bank_sel,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic              prog_req,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   output logic [DATA_W-1:0] rd_word,
   output logic [15:0]       otp_ctrl,
   output logic              otp_ptr_inc,
   output logic              otp_rd_en,
   output logic              otp_bank,
   input  logic [DATA_W-1:0] otp_rd_data
);
   localparam int LOW_CYC = (ns_to_cyc(STROBE_LOW_NS, CLK_MHZ) < 1) ? 1 : ns_to_cyc(STROBE_LOW_NS, CLK_MHZ);
   localparam int SET_CYC = (ns_to_cyc(SETTLE_NS, CLK_MHZ) < 1) ? 1 : ns_to_cyc(SETTLE_NS, CLK_MHZ);
   localparam int MAX_CYC = (LOW_CYC > SET_CYC) ? LOW_CYC : SET_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CTRL_W-1:0] CTRL_IDLE = CTRL_W'(1) << BIT_MODE;

   generate
      if (CLK_MHZ < 1)       begin : g_bad_clk   $error("CLK_MHZ must be positive");   end
      if (NORTH_WORDS < 1)   begin : g_bad_north $error("NORTH_WORDS must be >= 1");   end
      if (SOUTH_WORDS < 1)   begin : g_bad_south $error("SOUTH_WORDS must be >= 1");   end
      if (DATA_W < 1)        begin : g_bad_data  $error("DATA_W must be positive");    end
      if (CTRL_W != 16)      begin : g_bad_ctrl  $error("control word must be 16 bits"); end
   endgenerate

   seq_state_e        state_q;
   logic              mode_q, prst_q, porb_q, strb_q, pinc_q, rden_q, bank_q;
   logic [IDX_W-1:0]  idx_q, wcnt_q, lim_q;
   logic [1:0]        status_q;
   logic [IDX_W-1:0]  req_words;
   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_val;
   logic              take;

   assign req_words = bank_sel ? IDX_W'(SOUTH_WORDS) : IDX_W'(NORTH_WORDS);

   always_comb begin
      tmr_load = (state_q == S_SHI) || (state_q == S_SHI2) ||
                 ((state_q == S_READ) && (wcnt_q != lim_q));
      tmr_val  = (state_q == S_SHI) ? CNT_W'(LOW_CYC - 1) : CNT_W'(SET_CYC - 1);
   end

   otp_dly_cnt #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   assign take = (state_q == S_READ) && (wcnt_q == idx_q);

   otp_word_latch #(.W(DATA_W)) u_word (
      .clk(clk), .rst_n(rst_n), .take(take), .din(otp_rd_data), .dout(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         mode_q   <= 1'b1;
         prst_q   <= 1'b0;
         porb_q   <= 1'b0;
         strb_q   <= 1'b0;
         pinc_q   <= 1'b0;
         rden_q   <= 1'b0;
         bank_q   <= 1'b0;
         idx_q    <= '0;
         wcnt_q   <= '0;
         lim_q    <= '0;
         status_q <= ST_OK;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               if (prog_req) begin
                  status_q <= ST_UNSUP;
                  state_q  <= S_DONE;
               end else if (word_idx >= req_words) begin
                  status_q <= ST_BADIX;
                  state_q  <= S_DONE;
               end else begin
                  bank_q  <= bank_sel;
                  idx_q   <= word_idx;
                  lim_q   <= req_words - 1'b1;
                  wcnt_q  <= '0;
                  state_q <= S_MODE;
               end
            end
            S_MODE: begin mode_q <= 1'b0; state_q <= S_POR;  end
            S_POR:  begin porb_q <= 1'b1; state_q <= S_PINC; end
            S_PINC: begin pinc_q <= 1'b1; state_q <= S_RSET; end
            S_RSET: begin prst_q <= 1'b1; state_q <= S_RCLR; end
            S_RCLR: begin prst_q <= 1'b0; state_q <= S_SHI;  end
            S_SHI:  begin strb_q <= 1'b1; state_q <= S_SLO;  end
            S_SLO: begin
               strb_q <= 1'b0;
               if (tmr_exp) state_q <= S_SHI2;
            end
            S_SHI2: begin strb_q <= 1'b1; state_q <= S_WAIT; end
            S_WAIT: if (tmr_exp) begin
               rden_q  <= 1'b1;
               state_q <= S_READ;
            end
            S_READ: begin
               rden_q <= 1'b0;
               if (wcnt_q == lim_q) state_q <= S_FIN;
               else begin
                  wcnt_q  <= wcnt_q + 1'b1;
                  state_q <= S_WAIT;
               end
            end
            S_FIN: begin
               status_q <= ST_OK;
               mode_q   <= 1'b1;
               porb_q   <= 1'b0;
               pinc_q   <= 1'b0;
               strb_q   <= 1'b0;
               state_q  <= S_DONE;
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      otp_ctrl           = '0;
      otp_ctrl[BIT_MODE] = mode_q;
      otp_ctrl[BIT_PRST] = prst_q;
      otp_ctrl[BIT_PORB] = porb_q;
      otp_ctrl[BIT_STRB] = strb_q;
   end

   assign otp_ptr_inc = pinc_q;
   assign otp_rd_en   = rden_q;
   assign otp_bank    = bank_q;
   assign busy        = (state_q != S_IDLE);
   assign done        = (state_q == S_DONE);
   assign status      = status_q;

   // checker state: strobe low run length and settle gap
   logic              strb_d, armed_q;
   logic [CNT_W:0]    low_run, gap_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_d  <= 1'b0;
         armed_q <= 1'b0;
         low_run <= '0;
         gap_run <= '0;
      end else begin
         strb_d <= otp_ctrl[BIT_STRB];
         if (!otp_ctrl[BIT_STRB] && low_run != {(CNT_W+1){1'b1}}) low_run <= low_run + 1'b1;
         else if (otp_ctrl[BIT_STRB]) low_run <= '0;
         if (strb_d && !otp_ctrl[BIT_STRB] && otp_ptr_inc) armed_q <= 1'b1;
         else if (otp_ctrl[BIT_STRB] && !strb_d)           armed_q <= 1'b0;
         if (otp_rd_en || (otp_ctrl[BIT_STRB] && !strb_d)) gap_run <= 1;
         else if (gap_run != {(CNT_W+1){1'b1}})            gap_run <= gap_run + 1'b1;
      end
   end

   assert_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(otp_ctrl[BIT_STRB]) && armed_q) |-> (low_run >= (CNT_W+1)'(LOW_CYC)));

   assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      otp_rd_en |-> (gap_run >= (CNT_W+1)'(SET_CYC)));

   assert_read_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      otp_rd_en |-> (!otp_ctrl[BIT_MODE] && otp_ctrl[BIT_PORB] && otp_ptr_inc && otp_ctrl[BIT_STRB]));

   assert_prst_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      otp_ctrl[BIT_PRST] |=> !otp_ctrl[BIT_PRST]);

   assert_prst_after_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(otp_ctrl[BIT_PRST]) |-> (otp_ptr_inc && otp_ctrl[BIT_PORB] && !otp_ctrl[BIT_MODE]));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(otp_bank));

   assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != ST_OK) |-> (otp_ctrl == CTRL_IDLE && !otp_ptr_inc && $stable(rd_word)));

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (otp_ctrl == CTRL_IDLE && !otp_ptr_inc && !otp_rd_en));
endmodule

// File: tb/tb_otp_par_rd_seq.sv
`timescale 1ns/1ps
module tb_otp_par_rd_seq;
   localparam int CLK_MHZ = 200;
   localparam int LOW_NS  = 100;
   localparam int SET_NS  = 250;
   localparam int IDX_W   = 3;
   localparam int LOW_EXP = (LOW_NS * CLK_MHZ + 999) / 1000;
   localparam int SET_EXP = (SET_NS * CLK_MHZ + 999) / 1000;

   logic clk = 0, rst_n = 0;
   logic start = 0, bank_sel = 0, prog_req = 0;
   logic [IDX_W-1:0] word_idx = '0;
   logic busy, done, otp_ptr_inc, otp_rd_en, otp_bank;
   logic [1:0] status;
   logic [31:0] rd_word, otp_rd_data;
   logic [15:0] otp_ctrl;

   always #2.5 clk = ~clk;

   otp_par_rd_seq #(.CLK_MHZ(CLK_MHZ), .STROBE_LOW_NS(LOW_NS), .SETTLE_NS(SET_NS)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel), .word_idx(word_idx),
      .prog_req(prog_req), .busy(busy), .done(done), .status(status), .rd_word(rd_word),
      .otp_ctrl(otp_ctrl), .otp_ptr_inc(otp_ptr_inc), .otp_rd_en(otp_rd_en),
      .otp_bank(otp_bank), .otp_rd_data(otp_rd_data)
   );

   function automatic logic [31:0] fdat(input logic b, input int p);
      return 32'hC0DE_0000 | (32'(b) << 12) | 32'((p * 16'h0111 + 16'h0055) & 16'h0FFF);
   endfunction

   // fuse macro model and edge recorder
   int cyc = 0, ptr = 0, nreads = 0, mingap = 0;
   int t_mode, t_por, t_inc, t_rr, t_rf, t_s1, t_sf, t_s2, last_ev, sphase;
   logic [15:0] pc = 16'h8000;
   logic pinc_p = 0;
   assign otp_rd_data = fdat(otp_bank, ptr);

   task automatic clear_rec();
      t_mode = -1; t_por = -1; t_inc = -1; t_rr = -1; t_rf = -1;
      t_s1 = -1; t_sf = -1; t_s2 = -1; last_ev = -1; sphase = 0;
      nreads = 0; mingap = 1 << 30;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (pc[15] && !otp_ctrl[15]) t_mode = cyc;
      if (!pc[13] && otp_ctrl[13]) t_por = cyc;
      if (!pinc_p && otp_ptr_inc)  t_inc = cyc;
      if (!pc[14] && otp_ctrl[14]) t_rr = cyc;
      if (pc[14] && !otp_ctrl[14]) t_rf = cyc;
      if (!pc[3] && otp_ctrl[3] && otp_ptr_inc) begin
         if (sphase == 0) begin t_s1 = cyc; sphase = 1; end
         else if (sphase == 2) begin t_s2 = cyc; last_ev = cyc; sphase = 3; end
      end
      if (pc[3] && !otp_ctrl[3] && sphase == 1) begin t_sf = cyc; sphase = 2; end
      if (otp_rd_en) begin
         nreads = nreads + 1;
         if (last_ev >= 0 && cyc - last_ev < mingap) mingap = cyc - last_ev;
         if (last_ev < 0) mingap = 0;
         last_ev = cyc;
      end
      if (otp_ctrl[14]) ptr <= 0;
      else if (otp_rd_en && otp_ptr_inc) ptr <= ptr + 1;
      pc = otp_ctrl;
      pinc_p = otp_ptr_inc;
   end

   int total = 0, bad = 0;
   bit hung = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_req(input logic b, input int idx, input logic prg, input bit poke);
      logic [31:0] prev;
      int words, n;
      bit seen_done;
      words = b ? 4 : 3;
      prev = rd_word;
      clear_rec();
      @(negedge clk);
      start = 1; bank_sel = b; word_idx = IDX_W'(idx); prog_req = prg;
      @(negedge clk);
      start = 0;
      if (!prg && idx < words) chk(busy == 1, "R9 busy after start", busy, 1);
      n = 0; seen_done = 0;
      while (!seen_done && n < 2000) begin
         if (poke && n == 30) begin
            start = 1; bank_sel = ~b; word_idx = '0; prog_req = 1;
            @(negedge clk); n++;
            start = 0; prog_req = 0;
            if (done) seen_done = 1;
         end else begin
            if (done) seen_done = 1;
            else begin @(negedge clk); n++; end
         end
      end
      if (!seen_done) begin hung = 1; chk(0, "R9 done never seen", 0, 1); return; end
      if (prg) begin
         chk(status == 2'd2, "R8 status", status, 2);
         chk(rd_word == prev, "R8 rd_word kept", rd_word, prev);
         chk(nreads == 0 && t_mode < 0, "R8 no fuse activity", nreads, 0);
      end else if (idx >= words) begin
         chk(status == 2'd1, "R7 status", status, 1);
         chk(rd_word == prev, "R7 rd_word kept", rd_word, prev);
         chk(nreads == 0 && t_mode < 0, "R7 no fuse activity", nreads, 0);
      end else begin
         chk(status == 2'd0, "R6 status", status, 0);
         chk(rd_word == fdat(b, idx), "R6 rd_word", rd_word, fdat(b, idx));
         chk(nreads == words, "R5 read count", nreads, words);
         chk(t_mode >= 0 && t_por > t_mode && t_inc > t_por && t_rr > t_inc,
             "R2 bring-up order", t_rr, t_inc + 1);
         chk(t_rf == t_rr + 1, "R2 pointer reset width", t_rf - t_rr, 1);
         chk(t_s1 > t_rf && t_sf == t_s1 + 1, "R3 strobe high-low", t_sf - t_s1, 1);
         chk(t_s2 - t_sf >= LOW_EXP, "R3 strobe low time", t_s2 - t_sf, LOW_EXP);
         chk(mingap >= SET_EXP, "R4 settle gap", mingap, SET_EXP);
         if (poke) chk(status == 2'd0 && rd_word == fdat(b, idx), "R9 start while busy ignored",
                       rd_word, fdat(b, idx));
      end
      @(negedge clk);
      chk(done == 0, "R9 done one cycle", done, 0);
      chk(otp_ctrl == 16'h8000 && !otp_ptr_inc && !busy, "R10 idle lines", otp_ctrl, 16'h8000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 0);
      chk(otp_ctrl == 16'h8000, "R1 ctrl reset", otp_ctrl, 16'h8000);
      chk(!otp_ptr_inc && !otp_rd_en, "R1 ptr_inc/rd_en reset", {otp_ptr_inc, otp_rd_en}, 0);
      chk(rd_word == 0 && status == 0, "R1 outputs reset", rd_word, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      for (int p = 0; p < 2; p++)
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++)
               if (!hung) run_req(b[0], i, p[0], 0);
      if (!hung) run_req(1'b1, 2, 1'b0, 1);
      if (!hung) run_req(1'b0, 1, 1'b0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      while (cyc < 150000) @(negedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule